// File: doc/BRIEF.md
# Configurable PLD Macrocell Register

This block models a single macrocell of a programmable logic device. It receives two sum-of-products terms and a set of configuration bits. From these it produces a pin-side output and an internal feedback value. The storage bit can act as a D, T, JK or SR flip-flop, or as a transparent latch. The output can bypass the storage bit and carry the combinational sum instead, and a final XOR sets the pin polarity.

All clocks seen by the cell are ordinary level signals sampled by the chip clock `clk`. A clock "edge" is a change between two consecutive samples. In synchronous mode, one of the block clocks is selected and its rising transition clocks the cell. Two block-wide initialisation terms give preset and reset, and a swap bit exchanges their roles. In asynchronous mode, a per-cell product-term clock is used on the edge chosen by a configuration bit. One per-cell initialisation term then gives either preset or reset.

Two test controls sit above the logic. Preload writes any value into the storage bit. Observe shows the storage bit at the pin and blocks every product term from changing it.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low the storage bit is 0, so `fb_out` is 0 in registered mode and `pin_out` equals `cfg_inv`.
- R2: With `cfg_kind`=0 (D) in synchronous mode, the cell loads `sop_a` only on a rising transition of `blk_clk[cfg_clk_sel]`. Transitions on unselected clocks have no effect.
- R3: With `cfg_kind`=1 (T), a clock event inverts the stored bit when `sop_a` is 1 and keeps it when `sop_a` is 0.
- R4: With `cfg_kind`=2 (JK, J=`sop_a`, K=`sop_b`), a clock event acts as follows: 00 holds, 01 clears, 10 sets, 11 toggles.
- R5: With `cfg_kind`=3 (SR, S=`sop_a`, R=`sop_b`), a clock event acts as follows: 00 holds, 01 clears, 10 sets, 11 holds. While both are 1, `sr_illegal` is 1.
- R6: With `cfg_kind`=4 (latch), the stored bit follows `sop_a` one `clk` after any cycle in which the selected gate level equals `cfg_gate_hi`. It holds otherwise.
- R7: In asynchronous mode (`cfg_async`=1) the cell is clocked by `pt_clk`. The rising transition is used when `cfg_fall`=0 and the falling transition when `cfg_fall`=1. Block clocks are ignored.
- R8: In synchronous mode, `blk_init[0]` clears and `blk_init[1]` sets the bit without any clock event, and `cfg_swap`=1 exchanges the two roles. `cell_init` has no effect in this mode.
- R9: In asynchronous mode, `cell_init` sets the bit when `cfg_cell_set`=1 and clears it when `cfg_cell_set`=0. `blk_init` has no effect in this mode.
- R10: When a clear term and a set term are active together, the bit is cleared.
- R11: `fb_out` is `sop_a` when `cfg_comb`=1 and the stored bit when `cfg_comb`=0. `pin_out` is `fb_out` XOR `cfg_inv`.
- R12: `preload` loads `pre_val` on the next `clk`, taking priority over the initialisation terms and clock events.
- R13: While `observe` is 1, `pin_out` shows the stored bit XOR `cfg_inv` even when `cfg_comb`=1. Clocks and initialisation terms cannot change the bit; only `preload` can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples every clock and control level |
| rst_n | input | 1 | Active-low power-up clear |
| blk_clk | input | NCLK | Block clock levels |
| pt_clk | input | 1 | Per-cell product-term clock level |
| sop_a | input | 1 | First sum-of-products term (D, T, J, S, latch data, combinational value) |
| sop_b | input | 1 | Second sum-of-products term (K, R) |
| blk_init | input | 2 | Block initialisation terms, bit 0 clears and bit 1 sets when not swapped |
| cell_init | input | 1 | Per-cell initialisation term for asynchronous mode |
| cfg_async | input | 1 | 1 selects asynchronous mode |
| cfg_clk_sel | input | log2(NCLK) | Block clock index |
| cfg_fall | input | 1 | Asynchronous mode: 1 selects the falling product-term clock edge |
| cfg_kind | input | 3 | Storage type: 0 D, 1 T, 2 JK, 3 SR, 4 latch, others D |
| cfg_comb | input | 1 | 1 routes the combinational sum to the output |
| cfg_inv | input | 1 | Output polarity inversion |
| cfg_swap | input | 1 | Exchanges the preset and reset roles of the block terms |
| cfg_cell_set | input | 1 | 1 makes `cell_init` a preset, 0 a reset |
| cfg_gate_hi | input | 1 | Gate level at which the latch is transparent |
| preload | input | 1 | Test load of `pre_val` |
| pre_val | input | 1 | Value written by `preload` |
| observe | input | 1 | Test observe: registered view and product terms masked |
| pin_out | output | 1 | Output toward the pin, after polarity |
| fb_out | output | 1 | Internal feedback value, before polarity |
| sr_illegal | output | 1 | SR type with both inputs active |

## Verification
A wrong stored bit appears at `fb_out` and `pin_out` in the first sampling after the clock event or initialisation that caused it. The error then persists until the next event that writes the bit. A wrong edge history shows up as a missed or extra capture on the following transition of the selected clock. Each cycle, a bench reference model predicts all three outputs, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NCLK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCLK-1:0]          blk_clk,
  input  logic                     pt_clk,
  input  logic                     sop_a,
  input  logic                     sop_b,
  input  logic [1:0]               blk_init,
  input  logic                     cell_init,
  input  logic                     cfg_async,
  input  logic [$clog2(NCLK)-1:0]  cfg_clk_sel,
  input  logic                     cfg_fall,
  input  logic [2:0]               cfg_kind,
  input  logic                     cfg_comb,
  input  logic                     cfg_inv,
  input  logic                     cfg_swap,
  input  logic                     cfg_cell_set,
  input  logic                     cfg_gate_hi,
  input  logic                     preload,
  input  logic                     pre_val,
  input  logic                     observe,
  output logic                     pin_out,
  output logic                     fb_out,
  output logic                     sr_illegal
);
  localparam logic [2:0] K_D = 3'd0, K_T = 3'd1, K_JK = 3'd2, K_SR = 3'd3, K_LAT = 3'd4;

  logic            q;
  logic [NCLK-1:0] prev_blk;
  logic            prev_pt;
  logic            a, b, lvl, lvl_prev, edge_hit, gate_open;
  logic            clr_term, set_term, upd, nxt;

  assign a = sop_a & ~observe;
  assign b = sop_b & ~observe;

  assign lvl      = cfg_async ? pt_clk  : blk_clk[cfg_clk_sel];
  assign lvl_prev = cfg_async ? prev_pt : prev_blk[cfg_clk_sel];
  assign edge_hit = (cfg_async && cfg_fall) ? (lvl_prev & ~lvl) : (~lvl_prev & lvl);
  assign gate_open = (lvl == cfg_gate_hi);

  assign clr_term = ~observe & (cfg_async ? (cell_init & ~cfg_cell_set)
                                          : (cfg_swap ? blk_init[1] : blk_init[0]));
  assign set_term = ~observe & (cfg_async ? (cell_init & cfg_cell_set)
                                          : (cfg_swap ? blk_init[0] : blk_init[1]));

  assign upd = ~observe & ((cfg_kind == K_LAT) | edge_hit);

  always_comb begin
    case (cfg_kind)
      K_D:   nxt = a;
      K_T:   nxt = q ^ a;
      K_JK:  nxt = (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      K_SR:  nxt = (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
      K_LAT: nxt = gate_open ? a : q;
      default: nxt = a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= 1'b0;
      prev_blk <= '0;
      prev_pt  <= 1'b0;
    end else begin
      prev_blk <= blk_clk;
      prev_pt  <= pt_clk;
      if (preload)       q <= pre_val;
      else if (clr_term) q <= 1'b0;
      else if (set_term) q <= 1'b1;
      else if (upd)      q <= nxt;
    end
  end

  assign fb_out     = (cfg_comb & ~observe) ? sop_a : q;
  assign pin_out    = fb_out ^ cfg_inv;
  assign sr_illegal = (cfg_kind == K_SR) & a & b;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] blk_init,
  input logic       cell_init,
  input logic       cfg_async,
  input logic       cfg_cell_set,
  input logic       cfg_inv,
  input logic       preload,
  input logic       pre_val,
  input logic       observe,
  input logic       pin_out,
  input logic       q
);
  assert_powerup_clear_R1: assert property (@(posedge clk) !rst_n |-> q == 1'b0);

  assert_async_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async && cell_init && !preload && !observe) |=> q == $past(cfg_cell_set));

  assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async && blk_init == 2'b11 && !preload && !observe) |=> q == 1'b0);

  assert_preload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    preload |=> q == $past(pre_val));

  assert_observe_pin_R13: assert property (@(posedge clk) disable iff (!rst_n)
    observe |-> pin_out == (q ^ cfg_inv));

  assert_observe_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (observe && !preload) |=> $stable(q));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blk_init(blk_init), .cell_init(cell_init),
  .cfg_async(cfg_async), .cfg_cell_set(cfg_cell_set), .cfg_inv(cfg_inv),
  .preload(preload), .pre_val(pre_val), .observe(observe),
  .pin_out(pin_out), .q(q)
);

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
module sim_pld_macrocell;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] blk_clk;
  logic pt_clk, sop_a, sop_b, cell_init;
  logic [1:0] blk_init, cfg_clk_sel;
  logic cfg_async, cfg_fall, cfg_comb, cfg_inv, cfg_swap, cfg_cell_set, cfg_gate_hi;
  logic [2:0] cfg_kind;
  logic preload, pre_val, observe;
  logic pin_out, fb_out, sr_illegal;

  int total = 0, bad = 0;
  bit finished = 0;
  logic m_q, m_pp;
  logic [3:0] m_pb;

  always #4 clk = ~clk;

  pld_macrocell #(.NCLK(4)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_clk(blk_clk), .pt_clk(pt_clk),
    .sop_a(sop_a), .sop_b(sop_b), .blk_init(blk_init), .cell_init(cell_init),
    .cfg_async(cfg_async), .cfg_clk_sel(cfg_clk_sel), .cfg_fall(cfg_fall),
    .cfg_kind(cfg_kind), .cfg_comb(cfg_comb), .cfg_inv(cfg_inv), .cfg_swap(cfg_swap),
    .cfg_cell_set(cfg_cell_set), .cfg_gate_hi(cfg_gate_hi),
    .preload(preload), .pre_val(pre_val), .observe(observe),
    .pin_out(pin_out), .fb_out(fb_out), .sr_illegal(sr_illegal));

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s pin/fb/ill got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic expect_fb(input string tag, input logic exp);
    total++;
    if (fb_out !== exp) begin
      bad++;
      $display("FAIL %s fb_out got=%b exp=%b", tag, fb_out, exp);
    end
  endtask

  function automatic logic ref_next(logic q, logic a, logic b, logic [2:0] kind, logic gopen);
    case (kind)
      3'd1: return q ^ a;
      3'd2: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      3'd3: return (a && !b) ? 1'b1 : ((b && !a) ? 1'b0 : q);
      3'd4: return gopen ? a : q;
      default: return a;
    endcase
  endfunction

  task automatic step(input string tag);
    logic ae, be, lv, lvp, ev, clr, st, fe, ie;
    ae  = sop_a & ~observe;
    be  = sop_b & ~observe;
    lv  = cfg_async ? pt_clk : blk_clk[cfg_clk_sel];
    lvp = cfg_async ? m_pp : m_pb[cfg_clk_sel];
    ev  = (cfg_async && cfg_fall) ? (lvp && !lv) : (!lvp && lv);
    if (cfg_async) begin
      clr = cell_init && !cfg_cell_set;
      st  = cell_init && cfg_cell_set;
    end else begin
      clr = cfg_swap ? blk_init[1] : blk_init[0];
      st  = cfg_swap ? blk_init[0] : blk_init[1];
    end
    if (observe) begin clr = 0; st = 0; end
    if (preload) m_q = pre_val;
    else if (clr) m_q = 1'b0;
    else if (st) m_q = 1'b1;
    else if (!observe && (cfg_kind == 3'd4 || ev))
      m_q = ref_next(m_q, ae, be, cfg_kind, lv == cfg_gate_hi);
    m_pb = blk_clk;
    m_pp = pt_clk;
    @(posedge clk);
    @(negedge clk);
    fe = (cfg_comb && !observe) ? sop_a : m_q;
    ie = (cfg_kind == 3'd3) && ae && be;
    check(tag, {pin_out, fb_out, sr_illegal}, {fe ^ cfg_inv, fe, ie});
  endtask

  task automatic pulse(input string tag);
    if (cfg_async) pt_clk = 1'b0; else blk_clk[cfg_clk_sel] = 1'b0;
    step(tag);
    if (cfg_async) pt_clk = 1'b1; else blk_clk[cfg_clk_sel] = 1'b1;
    step(tag);
  endtask

  task automatic quiet();
    blk_clk = '0; pt_clk = 0; sop_a = 0; sop_b = 0; blk_init = 0; cell_init = 0;
    cfg_async = 0; cfg_clk_sel = 0; cfg_fall = 0; cfg_kind = 0; cfg_comb = 0;
    cfg_inv = 0; cfg_swap = 0; cfg_cell_set = 0; cfg_gate_hi = 1;
    preload = 0; pre_val = 0; observe = 0;
  endtask

  task automatic load(input logic v);
    preload = 1; pre_val = v; step("R12 preload");
    preload = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    quiet();
    cfg_inv = 1;
    rst_n = 1'b0;
    m_q = 0; m_pb = '0; m_pp = 0;
    repeat (3) @(negedge clk);
    total++;
    if (pin_out !== 1'b1 || fb_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset got pin=%b fb=%b exp pin=1 fb=0", pin_out, fb_out);
    end
    rst_n = 1'b1;
    cfg_inv = 0;
    step("R1 idle after reset"); expect_fb("R1 cleared", 1'b0);

    // R2 D type, selected clock only
    cfg_clk_sel = 2; sop_a = 1;
    blk_clk[1] = 1; step("R2 other clock"); expect_fb("R2 unselected edge ignored", 1'b0);
    blk_clk[1] = 0; step("R2");
    blk_clk[2] = 1; step("R2 edge"); expect_fb("R2 capture", 1'b1);
    sop_a = 0; step("R2 level"); expect_fb("R2 no edge holds", 1'b1);

    // R3 T type
    cfg_kind = 1; sop_a = 1;
    pulse("R3"); expect_fb("R3 toggle to 0", 1'b0);
    pulse("R3"); expect_fb("R3 toggle to 1", 1'b1);
    sop_a = 0; pulse("R3"); expect_fb("R3 hold", 1'b1);

    // R4 JK type
    cfg_kind = 2; sop_a = 1; sop_b = 1;
    pulse("R4"); expect_fb("R4 JK 11 toggles", 1'b0);
    pulse("R4"); expect_fb("R4 JK 11 toggles again", 1'b1);
    sop_a = 0; pulse("R4"); expect_fb("R4 JK 01 clears", 1'b0);
    sop_a = 1; sop_b = 0; pulse("R4"); expect_fb("R4 JK 10 sets", 1'b1);
    sop_a = 0; pulse("R4"); expect_fb("R4 JK 00 holds", 1'b1);

    // R5 SR type
    cfg_kind = 3; sop_a = 1; sop_b = 1;
    pulse("R5"); expect_fb("R5 SR 11 holds", 1'b1);
    total++;
    if (sr_illegal !== 1'b1) begin bad++; $display("FAIL R5 sr_illegal got=%b exp=1", sr_illegal); end
    sop_a = 0; pulse("R5"); expect_fb("R5 SR 01 clears", 1'b0);
    sop_a = 1; sop_b = 1; pulse("R5"); expect_fb("R5 SR 11 holds 0", 1'b0);
    sop_b = 0; pulse("R5"); expect_fb("R5 SR 10 sets", 1'b1);

    // R6 latch
    cfg_kind = 4; cfg_clk_sel = 0; cfg_gate_hi = 1; blk_clk = '0;
    blk_clk[0] = 1; sop_a = 0; step("R6 open"); expect_fb("R6 transparent 0", 1'b0);
    sop_a = 1; step("R6 open"); expect_fb("R6 transparent 1", 1'b1);
    blk_clk[0] = 0; sop_a = 0; step("R6 closed"); expect_fb("R6 holds", 1'b1);
    cfg_gate_hi = 0; step("R6 low gate"); expect_fb("R6 low-transparent", 1'b0);

    // R7 asynchronous clock edge select
    cfg_kind = 0; cfg_async = 1; cfg_fall = 1; blk_clk = '0; pt_clk = 0;
    load(1'b0);
    sop_a = 1; pt_clk = 1; step("R7 rise"); expect_fb("R7 rise ignored when falling chosen", 1'b0);
    pt_clk = 0; step("R7 fall"); expect_fb("R7 falling edge captures", 1'b1);
    blk_clk[0] = 1; sop_a = 0; step("R7 blk"); expect_fb("R7 block clock ignored", 1'b1);
    cfg_fall = 0; pt_clk = 1; step("R7 rise"); expect_fb("R7 rising edge captures", 1'b0);

    // R8 synchronous initialisation
    cfg_async = 0; blk_clk = '0; pt_clk = 0;
    load(1'b1);
    blk_init = 2'b01; step("R8"); expect_fb("R8 term0 clears", 1'b0);
    blk_init = 2'b10; step("R8"); expect_fb("R8 term1 sets", 1'b1);
    cfg_swap = 1; blk_init = 2'b01; step("R8"); expect_fb("R8 swapped term0 sets", 1'b1);
    blk_init = 2'b10; step("R8"); expect_fb("R8 swapped term1 clears", 1'b0);
    blk_init = 0; cell_init = 1; cfg_cell_set = 1; step("R8"); expect_fb("R8 cell term ignored", 1'b0);
    cell_init = 0; cfg_swap = 0;

    // R9 asynchronous initialisation
    cfg_async = 1; cell_init = 1; cfg_cell_set = 1; step("R9"); expect_fb("R9 cell preset", 1'b1);
    cfg_cell_set = 0; step("R9"); expect_fb("R9 cell reset", 1'b0);
    cell_init = 0; load(1'b1);
    blk_init = 2'b11; step("R9"); expect_fb("R9 block terms ignored", 1'b1);
    blk_init = 0; cfg_async = 0;

    // R10 both terms
    blk_init = 2'b11; step("R10"); expect_fb("R10 reset wins", 1'b0);
    cfg_swap = 1; load(1'b1); blk_init = 2'b11; step("R10"); expect_fb("R10 reset wins swapped", 1'b0);
    cfg_swap = 0;

    // R12 preload priority over init
    blk_init = 2'b01; preload = 1; pre_val = 1; step("R12"); expect_fb("R12 preload beats reset", 1'b1);
    preload = 0; blk_init = 0;

    // R11 polarity and combinational
    cfg_comb = 1; cfg_inv = 1; sop_a = 1; step("R11");
    total++;
    if (pin_out !== 1'b0 || fb_out !== 1'b1) begin
      bad++; $display("FAIL R11 comb inv got pin=%b fb=%b exp pin=0 fb=1", pin_out, fb_out);
    end
    cfg_inv = 0; sop_a = 0; step("R11 comb 0"); expect_fb("R11 combinational 0", 1'b0);

    // R13 observe
    load(1'b1);
    observe = 1; cfg_inv = 1; sop_a = 0; step("R13");
    total++;
    if (pin_out !== 1'b0 || fb_out !== 1'b1) begin
      bad++; $display("FAIL R13 observe view got pin=%b fb=%b exp pin=0 fb=1", pin_out, fb_out);
    end
    cfg_comb = 0; blk_clk[0] = 0; step("R13"); blk_clk[0] = 1; step("R13 edge");
    expect_fb("R13 clock masked", 1'b1);
    blk_init = 2'b01; step("R13 init"); expect_fb("R13 init masked", 1'b1);
    preload = 1; pre_val = 0; step("R13 preload"); expect_fb("R13 preload works", 1'b0);
    quiet();
    step("idle");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      blk_clk      = 4'($urandom);
      pt_clk       = 1'($urandom);
      sop_a        = 1'($urandom);
      sop_b        = 1'($urandom);
      blk_init     = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      cell_init    = ($urandom_range(0, 7) == 0);
      cfg_async    = 1'($urandom);
      cfg_clk_sel  = 2'($urandom);
      cfg_fall     = 1'($urandom);
      cfg_kind     = 3'($urandom_range(0, 5));
      cfg_comb     = ($urandom_range(0, 3) == 0);
      cfg_inv      = 1'($urandom);
      cfg_swap     = 1'($urandom);
      cfg_cell_set = 1'($urandom);
      cfg_gate_hi  = 1'($urandom);
      preload      = ($urandom_range(0, 15) == 0);
      pre_val      = 1'($urandom);
      observe      = ($urandom_range(0, 9) == 0);
      step("R11 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule